// File: doc/BRIEF.md
# Serial EEPROM Address Pointer Controller

This block is the command and address-tracking core of a byte-serial EEPROM slave on a single-wire bus. A separate bit-level front end decodes the line and hands it four kinds of one-cycle event: a complete received byte, a master-acknowledge edge, a master no-acknowledge edge and a standby pulse. From these the controller checks the start header and device address and decodes the command. It captures the two address bytes and keeps the array address pointer that the memory array uses for every data byte.

Three commands are understood: an addressed read, an addressed write and a current-address read. The current-address read takes no address bytes and starts from whatever value the pointer was left at. Reads stream sequential bytes for as long as the master acknowledges. Writes advance only inside a 16-byte page and wrap at the page end. The pointer moves only on an acknowledge or no-acknowledge edge that follows a data byte. A standby pulse in that position leaves the pointer unchanged. The pointer register has no reset, so its value after power-up is undefined. A synchronous active-low reset clears only the command state.

Top module: `eeprom_ptr_ctrl`

## Requirements
- R1: After reset, and until the first standby pulse, the controller ignores all bytes and acknowledge edges: `rd_stb` and `wr_vld` stay low.
- R2: A standby pulse arms the controller. A frame is accepted only if the first byte is 0x55 and the second is the device byte 0xA0 with bit 0 replaced by parameter `DEV_LSB`. Each byte takes effect on the acknowledge edge after it. Any other value silences the controller until the next standby pulse.
- R3: Command byte 0x03 (read) is followed by two address bytes, high byte first. Each address byte is loaded into the pointer on the acknowledge edge after it. `rd_stb` is high in the cycle after the low-byte acknowledge, with `mem_addr` equal to the received address.
- R4: During a read, each acknowledge edge after a data byte adds one to the full 16-bit pointer, so 0xFFFF becomes 0x0000. It also raises `rd_stb` for one cycle, with `mem_addr` showing the new value.
- R5: During a read, a no-acknowledge edge after a data byte adds one to the pointer and ends the command. Later acknowledge edges neither move the pointer nor raise `rd_stb` until the next standby pulse.
- R6: A standby pulse in the data phase, in place of an acknowledge edge, leaves the pointer unchanged and returns the controller to waiting for a start header. This holds for both reads and writes.
- R7: Command byte 0x06 (current-address read) takes no address bytes. `rd_stb` is high in the cycle after its acknowledge edge, with `mem_addr` equal to the pointer value left by the previous access.
- R8: Command byte 0x6C (write) is followed by two address bytes as in R3. In the cycle after each data byte arrives, `wr_vld` is high, `wr_data` holds that byte and `mem_addr` holds the address it is to be written to.
- R9: During a write, the acknowledge or no-acknowledge edge after a data byte adds one to the low 4 bits of the pointer only. The page is 16 bytes, so xxxF wraps to xxx0 and bits 15:4 are unchanged. A no-acknowledge also ends the command.
- R10: Any other command byte silences the controller until the next standby pulse: `rd_stb` and `wr_vld` stay low and `mem_addr` does not change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset of the command state |
| byte_vld | input | 1 | One-cycle pulse: a complete byte was received |
| byte_data | input | 8 | Received byte, valid with `byte_vld` |
| mak_edge | input | 1 | One-cycle pulse: master acknowledge edge |
| nomak_edge | input | 1 | One-cycle pulse: master no-acknowledge edge |
| standby | input | 1 | One-cycle pulse: standby pulse on the bus |
| mem_addr | output | 16 | Current array address (pointer) |
| rd_stb | output | 1 | One-cycle request to fetch the byte at `mem_addr` |
| wr_vld | output | 1 | One-cycle strobe: `wr_data` is to be written at `mem_addr` |
| wr_data | output | 8 | Write data byte |

## Verification
The case hardest to reach from the ports is a pointer step across a boundary. This means a read that rolls over from 0xFFFF to 0x0000, or a write that passes xxxF and must fall back to the start of the same page rather than move into the next one. Random write bursts start at random page offsets and run up to 20 bytes, so most of them cross a page end. Directed frames load 0xFFFE and 0x12FE and then acknowledge past the boundary. A standby pulse placed where an acknowledge is expected, followed by a current-address read, shows that the pointer did not move.

// File: rtl/eeprom_ptr_pkg.sv
// Shared constants and types for the serial EEPROM address pointer controller.
package eeprom_ptr_pkg;
    localparam int ADDR_W = 16;

    localparam logic [7:0] HDR_BYTE  = 8'h55;
    localparam logic [7:0] CMD_READ  = 8'h03;
    localparam logic [7:0] CMD_WRITE = 8'h6C;
    localparam logic [7:0] CMD_CUR   = 8'h06;

    typedef enum logic [2:0] {
        ST_IDLE, ST_HDR, ST_DEV, ST_CMD, ST_AHI, ST_ALO, ST_DATA
    } ctl_state_t;

    typedef enum logic [2:0] {
        PTR_HOLD, PTR_LD_HI, PTR_LD_LO, PTR_INC_SEQ, PTR_INC_PAGE
    } ptr_op_t;
endpackage

// File: rtl/eeprom_addr_ptr.sv
// Address pointer register.
// Loads address bytes and steps either across the full space (reads) or
// inside one page (writes). It has no reset on purpose: its power-up value
// is undefined. Assumes ADDR_W == 16 (two address bytes).
module eeprom_addr_ptr
    import eeprom_ptr_pkg::*;
#(
    parameter int PAGE_BITS = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  ptr_op_t           op,
    input  logic [7:0]        ld_byte,
    output logic [ADDR_W-1:0] ptr
);
    logic [ADDR_W-1:0] seq_next;
    logic [ADDR_W-1:0] page_next;

    // Full-width increment used by reads.
    assign seq_next = ptr + 1'b1;

    generate
        if (PAGE_BITS >= ADDR_W) begin : g_page_full
            // Page covers the whole array: plain increment.
            assign page_next = seq_next;
        end else begin : g_page_part
            logic [PAGE_BITS-1:0] low_inc;
            // Increment only the in-page offset; upper bits are kept.
            assign low_inc   = ptr[PAGE_BITS-1:0] + 1'b1;
            assign page_next = {ptr[ADDR_W-1:PAGE_BITS], low_inc};
        end
    endgenerate

    // Pointer update selected by the command FSM.
    always_ff @(posedge clk) begin
        case (op)
            PTR_LD_HI:    ptr[15:8] <= ld_byte;
            PTR_LD_LO:    ptr[7:0]  <= ld_byte;
            PTR_INC_SEQ:  ptr       <= seq_next;
            PTR_INC_PAGE: ptr       <= page_next;
            default:      ptr       <= ptr;
        endcase
    end

    assert_seq_inc_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (op == PTR_INC_SEQ) |=> (ptr == $past(ptr) + 16'd1));

    assert_page_upper_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (op == PTR_INC_PAGE) |=> (ptr[ADDR_W-1:PAGE_BITS] == $past(ptr[ADDR_W-1:PAGE_BITS])));

    assert_page_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (op == PTR_INC_PAGE) |=> (ptr[PAGE_BITS-1:0] == $past(ptr[PAGE_BITS-1:0]) + 1'b1));
endmodule

// File: rtl/eeprom_cmd_fsm.sv
// Frame and command state machine.
// Each header, device, command or address byte is held and then acted on
// at the acknowledge edge that follows it. In the data phase it issues
// pointer steps and the read/write strobes. Assumes the front end delivers
// one-cycle event pulses. A standby pulse has priority over every other event.
module eeprom_cmd_fsm
    import eeprom_ptr_pkg::*;
#(
    parameter logic [7:0] DEV_BYTE = 8'hA0
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       byte_vld,
    input  logic [7:0] byte_data,
    input  logic       mak_edge,
    input  logic       nomak_edge,
    input  logic       standby,
    output ptr_op_t    ptr_op,
    output logic [7:0] ptr_byte,
    output logic       rd_stb,
    output logic       wr_vld,
    output logic [7:0] wr_data
);
    ctl_state_t state, state_nx;
    logic       pend;
    logic [7:0] hold;
    logic       is_wr, is_wr_nx;
    logic       rd_nx;
    logic       hdr_phase;
    logic       take_byte;

    // Byte-collecting states before the data phase.
    assign hdr_phase = (state == ST_HDR) || (state == ST_DEV) || (state == ST_CMD)
                    || (state == ST_AHI) || (state == ST_ALO);
    // A byte is stored in any collecting state and in the write data phase.
    assign take_byte = byte_vld && !standby && !mak_edge && !nomak_edge
                    && (hdr_phase || (state == ST_DATA && is_wr));
    assign ptr_byte  = hold;
    assign wr_data   = hold;

    // Next state, pointer operation and read request.
    always_comb begin
        state_nx = state;
        ptr_op   = PTR_HOLD;
        rd_nx    = 1'b0;
        is_wr_nx = is_wr;
        if (standby) begin
            state_nx = ST_HDR;
        end else if (hdr_phase) begin
            if (nomak_edge) begin
                state_nx = ST_IDLE;
            end else if (mak_edge && pend) begin
                case (state)
                    ST_HDR: state_nx = (hold == HDR_BYTE) ? ST_DEV : ST_IDLE;
                    ST_DEV: state_nx = (hold == DEV_BYTE) ? ST_CMD : ST_IDLE;
                    ST_CMD: begin
                        if (hold == CMD_READ || hold == CMD_WRITE) begin
                            state_nx = ST_AHI;
                            is_wr_nx = (hold == CMD_WRITE);
                        end else if (hold == CMD_CUR) begin
                            state_nx = ST_DATA;
                            is_wr_nx = 1'b0;
                            rd_nx    = 1'b1;
                        end else begin
                            state_nx = ST_IDLE;
                        end
                    end
                    ST_AHI: begin
                        ptr_op   = PTR_LD_HI;
                        state_nx = ST_ALO;
                    end
                    default: begin
                        ptr_op   = PTR_LD_LO;
                        state_nx = ST_DATA;
                        rd_nx    = !is_wr;
                    end
                endcase
            end
        end else if (state == ST_DATA) begin
            if (is_wr) begin
                if ((mak_edge || nomak_edge) && pend) begin
                    ptr_op = PTR_INC_PAGE;
                end
            end else if (mak_edge || nomak_edge) begin
                ptr_op = PTR_INC_SEQ;
                rd_nx  = mak_edge;
            end
            if (nomak_edge) begin
                state_nx = ST_IDLE;
            end
        end
    end

    // State, held byte and strobe registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            pend   <= 1'b0;
            hold   <= 8'h00;
            is_wr  <= 1'b0;
            rd_stb <= 1'b0;
            wr_vld <= 1'b0;
        end else begin
            state  <= state_nx;
            is_wr  <= is_wr_nx;
            rd_stb <= rd_nx;
            wr_vld <= take_byte && (state == ST_DATA);
            if (take_byte) begin
                hold <= byte_data;
                pend <= 1'b1;
            end else if (standby || mak_edge || nomak_edge) begin
                pend <= 1'b0;
            end
        end
    end

    assert_standby_rearm_R6: assert property (@(posedge clk) disable iff (!rst_n)
        standby |=> (state == ST_HDR));

    assert_standby_noinc_R6: assert property (@(posedge clk) disable iff (!rst_n)
        standby |=> (!rd_stb && !wr_vld));

    assert_idle_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && !standby) |=> (state == ST_IDLE && !rd_stb && !wr_vld));

    assert_nomak_ends_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DATA && nomak_edge && !standby) |=> (state == ST_IDLE));

    assert_strobe_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_stb && wr_vld));
endmodule

// File: rtl/eeprom_ptr_ctrl.sv
// Top level of the serial EEPROM address pointer controller.
// Joins the command FSM with the pointer register. The page size must be a
// power of two. DEV_LSB selects the device-byte variant.
module eeprom_ptr_ctrl
    import eeprom_ptr_pkg::*;
#(
    parameter int   PAGE_BYTES = 16,
    parameter logic DEV_LSB    = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              byte_vld,
    input  logic [7:0]        byte_data,
    input  logic              mak_edge,
    input  logic              nomak_edge,
    input  logic              standby,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              rd_stb,
    output logic              wr_vld,
    output logic [7:0]        wr_data
);
    localparam int         PAGE_BITS = $clog2(PAGE_BYTES);
    localparam logic [7:0] DEV_BYTE  = {7'b1010000, DEV_LSB};

    ptr_op_t    op;
    logic [7:0] ld_byte;

    eeprom_cmd_fsm #(.DEV_BYTE(DEV_BYTE)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .byte_vld   (byte_vld),
        .byte_data  (byte_data),
        .mak_edge   (mak_edge),
        .nomak_edge (nomak_edge),
        .standby    (standby),
        .ptr_op     (op),
        .ptr_byte   (ld_byte),
        .rd_stb     (rd_stb),
        .wr_vld     (wr_vld),
        .wr_data    (wr_data)
    );

    eeprom_addr_ptr #(.PAGE_BITS(PAGE_BITS)) u_ptr (
        .clk     (clk),
        .rst_n   (rst_n),
        .op      (op),
        .ld_byte (ld_byte),
        .ptr     (mem_addr)
    );

    assert_reset_quiet_R1: assert property (@(posedge clk)
        !rst_n |=> (!rd_stb && !wr_vld));
endmodule

// File: tb/tb_eeprom_ptr_ctrl.sv
`timescale 1ns/1ps
module tb_eeprom_ptr_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        byte_vld = 1'b0;
    logic [7:0]  byte_data = 8'h00;
    logic        mak_edge = 1'b0;
    logic        nomak_edge = 1'b0;
    logic        standby = 1'b0;
    logic [15:0] mem_addr;
    logic        rd_stb;
    logic        wr_vld;
    logic [7:0]  wr_data;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    int rd_cnt = 0;
    int wr_cnt = 0;
    logic [15:0] exp_ptr;

    localparam logic [7:0] DEV = 8'hA0;

    eeprom_ptr_ctrl dut (
        .clk(clk), .rst_n(rst_n), .byte_vld(byte_vld), .byte_data(byte_data),
        .mak_edge(mak_edge), .nomak_edge(nomak_edge), .standby(standby),
        .mem_addr(mem_addr), .rd_stb(rd_stb), .wr_vld(wr_vld), .wr_data(wr_data)
    );

    always #4 clk = ~clk;

    always @(negedge clk) begin
        cycles++;
        if (rd_stb === 1'b1) rd_cnt++;
        if (wr_vld === 1'b1) wr_cnt++;
        if (cycles > 100000) begin
            errors++;
            $display("FAIL watchdog: act=%0d cycles exp<100000", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    function automatic logic [15:0] seq_next(input logic [15:0] a);
        return a + 16'd1;
    endfunction

    function automatic logic [15:0] page_next(input logic [15:0] a);
        return {a[15:4], a[3:0] + 4'd1};
    endfunction

    task automatic check(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic send(input logic [7:0] b);
        byte_vld = 1'b1; byte_data = b; tick(); byte_vld = 1'b0;
    endtask
    task automatic mak();   mak_edge = 1'b1;   tick(); mak_edge = 1'b0;   endtask
    task automatic nomak(); nomak_edge = 1'b1; tick(); nomak_edge = 1'b0; endtask
    task automatic stby();  standby = 1'b1;    tick(); standby = 1'b0;    endtask

    task automatic frame(input logic [7:0] cmd);
        stby(); send(8'h55); mak(); send(DEV); mak(); send(cmd); mak();
    endtask

    task automatic read_at(input logic [15:0] a);
        frame(8'h03); send(a[15:8]); mak(); send(a[7:0]); mak();
        exp_ptr = a;
        check(rd_stb === 1'b1 && mem_addr === a, "R3 addressed read", {15'd0, rd_stb, mem_addr}, {16'd1, a});
    endtask

    task automatic write_at(input logic [15:0] a);
        frame(8'h6C); send(a[15:8]); mak(); send(a[7:0]); mak();
        exp_ptr = a;
        check(rd_stb === 1'b0 && mem_addr === a, "R8 write address", {15'd0, rd_stb, mem_addr}, {16'd0, a});
    endtask

    task automatic write_byte(input logic [7:0] b, input bit last);
        send(b);
        check(wr_vld === 1'b1 && wr_data === b && mem_addr === exp_ptr, "R8 write strobe",
              {7'd0, wr_vld, wr_data, mem_addr}, {8'd1, b, exp_ptr});
        if (last) nomak(); else mak();
        exp_ptr = page_next(exp_ptr);
        check(mem_addr === exp_ptr && wr_vld === 1'b0, "R9 page step", {16'd0, mem_addr}, {16'd0, exp_ptr});
    endtask

    initial begin
        int r0;
        int w0;
        void'($urandom(32'd7153));
        repeat (3) tick();
        check(rd_stb === 1'b0 && wr_vld === 1'b0, "R1 reset outputs", {rd_stb, wr_vld}, 0);
        rst_n = 1'b1;
        tick();

        // R1: no standby yet, a complete read frame is ignored
        r0 = rd_cnt; w0 = wr_cnt;
        send(8'h55); mak(); send(DEV); mak(); send(8'h03); mak();
        send(8'h12); mak(); send(8'h34); mak(); mak(); tick();
        check(rd_cnt == r0 && wr_cnt == w0, "R1 ignored before standby", rd_cnt, r0);

        // R2: wrong device byte, then wrong header
        r0 = rd_cnt;
        stby(); send(8'h55); mak(); send(DEV ^ 8'h01); mak(); send(8'h06); mak(); mak(); tick();
        check(rd_cnt == r0, "R2 bad device byte", rd_cnt, r0);
        stby(); send(8'h54); mak(); send(DEV); mak(); send(8'h06); mak(); mak(); tick();
        check(rd_cnt == r0, "R2 bad header", rd_cnt, r0);

        // R3/R4/R5: random sequential reads
        for (int it = 0; it < 10; it++) begin
            int n;
            logic [15:0] a;
            a = 16'($urandom);
            n = 1 + int'($urandom % 6);
            read_at(a);
            for (int k = 0; k < n; k++) begin
                mak();
                exp_ptr = seq_next(exp_ptr);
                check(rd_stb === 1'b1 && mem_addr === exp_ptr, "R4 sequential read",
                      {15'd0, rd_stb, mem_addr}, {16'd1, exp_ptr});
            end
            nomak();
            exp_ptr = seq_next(exp_ptr);
            check(rd_stb === 1'b0 && mem_addr === exp_ptr, "R5 nomak step", {15'd0, rd_stb, mem_addr}, {16'd0, exp_ptr});
            r0 = rd_cnt;
            mak(); mak(); tick();
            check(rd_cnt == r0 && mem_addr === exp_ptr, "R5 ended command", {rd_cnt[15:0], mem_addr}, {r0[15:0], exp_ptr});
        end

        // R4: rollover of the full address space
        read_at(16'hFFFE);
        mak();
        check(mem_addr === 16'hFFFF, "R4 step to FFFF", mem_addr, 16'hFFFF);
        mak();
        check(mem_addr === 16'h0000 && rd_stb === 1'b1, "R4 wrap to 0000", mem_addr, 16'h0000);
        exp_ptr = 16'h0000;

        // R6: standby instead of an acknowledge keeps the pointer, R7 then reuses it
        stby();
        check(mem_addr === exp_ptr, "R6 read standby no step", mem_addr, exp_ptr);
        frame(8'h06);
        check(rd_stb === 1'b1 && mem_addr === exp_ptr, "R7 current read", {15'd0, rd_stb, mem_addr}, {16'd1, exp_ptr});
        mak();
        exp_ptr = seq_next(exp_ptr);
        check(rd_stb === 1'b1 && mem_addr === exp_ptr, "R7 current read stream", mem_addr, exp_ptr);
        nomak();
        exp_ptr = seq_next(exp_ptr);

        // R8/R9: random write bursts crossing page ends
        for (int it = 0; it < 8; it++) begin
            int n;
            n = 1 + int'($urandom % 20);
            write_at(16'($urandom));
            for (int k = 0; k < n; k++) write_byte(8'($urandom), k == n - 1);
        end

        // R9: directed wrap at the end of a page
        write_at(16'h12FE);
        write_byte(8'hA5, 1'b0);
        check(mem_addr === 16'h12FF, "R9 to page end", mem_addr, 16'h12FF);
        write_byte(8'h5A, 1'b0);
        check(mem_addr === 16'h12F0, "R9 wrap in page", mem_addr, 16'h12F0);

        // R6: standby after a write byte, R7 reads from the unmoved pointer
        send(8'h77);
        stby();
        check(mem_addr === 16'h12F0, "R6 write standby no step", mem_addr, 16'h12F0);
        frame(8'h06);
        check(rd_stb === 1'b1 && mem_addr === 16'h12F0, "R7 after write", mem_addr, 16'h12F0);
        nomak();
        exp_ptr = 16'h12F1;

        // R10: unknown command
        r0 = rd_cnt; w0 = wr_cnt;
        frame(8'h77);
        send(8'h00); mak(); send(8'h01); mak(); mak(); nomak(); tick();
        check(rd_cnt == r0 && wr_cnt == w0 && mem_addr === exp_ptr, "R10 unknown command",
              {rd_cnt[15:0], mem_addr}, {r0[15:0], exp_ptr});

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule